// File: doc/BRIEF.md
# Interlocked Handshake Read Bus

This block reads one word at a time from a memory-side agent over a single shared set of address/data lines. An initiator state machine sits on the requesting side. A target state machine sits on the memory side. The two coordinate through three control wires:

- a request line, raised by the initiator;
- a data-ready line, raised by the target;
- an acknowledge line, raised by whichever side is confirming the other.

Each side runs on its own clock. Each side sees the other's control wires only through a synchronizer and acts on the synchronized level, never on a raw edge.

A read starts when a command with an address is presented to an idle initiator. The initiator puts the address on the shared lines and raises request. The target captures the address, acknowledges it and starts its internal access at once. That access overlaps the return-to-zero of the request phase. The target then puts the word on the lines, and the two sides step back to all-low before the next command can be accepted. The initiator returns the word with a one-cycle done pulse.

The memory contents are fixed and computed from the address. The access latency is a parameter counted in target clock cycles.

Top module: `hsk_read_bus`

## Requirements
- R1: While either reset is asserted and after its release, busy, done, request, data-ready, acknowledge and both drive enables are low.
- R2: A completed read returns on done_data the low DW bits of (addr*3869 + 11079), where addr is the command address taken as an unsigned integer.
- R3: Each accepted command yields exactly one done pulse, one initiator clock wide; no done appears without an accepted command.
- R4: A command presented while busy is high is ignored: it yields no done pulse and does not change the word returned for the read in progress.
- R5: busy is high in the initiator cycle after a command is accepted, and it is high in the cycle done is pulsed.
- R6: The initiator drive enable and the target drive enable are never high at the same time.
- R7: While request is high, the shared lines carry the command address, zero-extended to DW. While data-ready is high, they carry the word defined in R2.
- R8: Data-ready rises only while both request and acknowledge are low.
- R9: The initiator drops request only while acknowledge is high.
- R10: Acknowledge falls only while data-ready is low.
- R11: Data-ready rises no earlier than LATENCY target cycles after the target raises acknowledge for the address. When LATENCY exceeds the handshake return-to-zero, it rises no later than LATENCY+2 cycles after.
- R12: When LATENCY is shorter than the return-to-zero of the request phase, data-ready waits for that return-to-zero and rises more than LATENCY+2 target cycles after acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ini | input | 1 | Initiator clock |
| rst_ini_n | input | 1 | Initiator reset, active low |
| clk_tgt | input | 1 | Target clock |
| rst_tgt_n | input | 1 | Target reset, active low |
| cmd_valid | input | 1 | Read command strobe |
| cmd_addr | input | AW | Read command address |
| busy | output | 1 | Initiator cannot accept a command |
| done | output | 1 | One-cycle read completion pulse |
| done_data | output | DW | Word returned with done |
| bus_req | output | 1 | Observed request wire |
| bus_rdy | output | 1 | Observed data-ready wire |
| bus_ack | output | 1 | Observed acknowledge wire (OR of both sides) |
| bus_data | output | DW | Observed shared address/data lines |
| ini_drv_en | output | 1 | Initiator drives the shared lines |
| tgt_drv_en | output | 1 | Target drives the shared lines |

## Verification
A target that captures the address at the wrong moment, or reads the wrong entry, is exposed when done_data arrives. That happens at the end of the same transaction, roughly two dozen target cycles after the command. A state machine that skips an interlock step is caught at the next control-wire edge, because the order of request, acknowledge and data-ready is checked on the raw wires. A broken latency counter moves the data-ready edge relative to acknowledge, and the bench measures that distance in target cycles on every read. A state that fails to return to idle keeps busy high, and the next command then never completes.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

   typedef enum logic [2:0] {
      I_IDLE,
      I_REQ,
      I_WRDY,
      I_ACK,
      I_DRAIN
   } ini_state_e;

   typedef enum logic [2:0] {
      T_IDLE,
      T_ACK,
      T_WAIT,
      T_RDY,
      T_END
   } tgt_state_e;

   // fixed memory image: a word per address, computed instead of tabulated
   function automatic logic [31:0] mem_word(input int unsigned a);
      return 32'(a * 32'd3869 + 32'd11079);
   endfunction

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hsk_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hsk_sync: W must be at least 1");
   end

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
      end else begin
         pipe[0] <= d;
         for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/hsk_initiator.sv
module hsk_initiator
   import hsk_pkg::*;
#(
   parameter int AW          = 4,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [AW-1:0] cmd_addr,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] done_data,
   input  logic [DW-1:0] bus_i,
   input  logic          rdy_i,
   input  logic          ack_i,
   output logic          req_o,
   output logic          ack_o,
   output logic          oe_o,
   output logic [DW-1:0] drv_o
);
   ini_state_e state;
   logic       s_rdy, s_ack;

   hsk_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({rdy_i, ack_i}),
      .q     ({s_rdy, s_ack})
   );

   assign busy = (state != I_IDLE) | s_rdy | s_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= I_IDLE;
         req_o     <= 1'b0;
         ack_o     <= 1'b0;
         oe_o      <= 1'b0;
         drv_o     <= '0;
         done      <= 1'b0;
         done_data <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            I_IDLE: if (cmd_valid && !s_rdy && !s_ack) begin
               drv_o <= DW'(cmd_addr);
               oe_o  <= 1'b1;
               req_o <= 1'b1;
               state <= I_REQ;
            end
            I_REQ: if (s_ack) begin
               req_o <= 1'b0;
               oe_o  <= 1'b0;
               state <= I_WRDY;
            end
            I_WRDY: if (s_rdy) begin
               done_data <= bus_i;
               ack_o     <= 1'b1;
               state     <= I_ACK;
            end
            I_ACK: if (!s_rdy) begin
               ack_o <= 1'b0;
               done  <= 1'b1;
               state <= I_DRAIN;
            end
            I_DRAIN: if (!s_ack && !s_rdy) state <= I_IDLE;
            default: state <= I_IDLE;
         endcase
      end
   end

   // R9
   req_fall_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_o) |-> ack_i);
   // R10
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_o) |-> !rdy_i);
   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R5
   busy_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
endmodule

// File: rtl/hsk_target.sv
module hsk_target
   import hsk_pkg::*;
#(
   parameter int AW          = 4,
   parameter int DW          = 16,
   parameter int LATENCY     = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] bus_i,
   input  logic          req_i,
   input  logic          ack_i,
   output logic          rdy_o,
   output logic          ack_o,
   output logic          oe_o,
   output logic [DW-1:0] drv_o
);
   localparam int DEPTH = 1 << AW;
   localparam int CW    = (LATENCY < 1) ? 1 : $clog2(LATENCY + 1);

   tgt_state_e    state;
   logic          s_req, s_ack;
   logic [AW-1:0] addr_q;
   logic          start, lat_done;
   logic [DW-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_mem
      assign mem[i] = DW'(mem_word(i));
   end

   hsk_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({req_i, ack_i}),
      .q     ({s_req, s_ack})
   );

   assign start = (state == T_IDLE) && s_req;

   if (LATENCY == 0) begin : g_nolat
      assign lat_done = 1'b1;
   end else begin : g_lat
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (start)      cnt <= CW'(LATENCY);
         else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
      assign lat_done = (cnt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= T_IDLE;
         addr_q <= '0;
         rdy_o  <= 1'b0;
         ack_o  <= 1'b0;
         oe_o   <= 1'b0;
         drv_o  <= '0;
      end else begin
         unique case (state)
            T_IDLE: if (start) begin
               addr_q <= bus_i[AW-1:0];
               ack_o  <= 1'b1;
               state  <= T_ACK;
            end
            T_ACK: if (!s_req) begin
               ack_o <= 1'b0;
               state <= T_WAIT;
            end
            T_WAIT: if (!s_ack && lat_done) begin
               drv_o <= mem[addr_q];
               oe_o  <= 1'b1;
               rdy_o <= 1'b1;
               state <= T_RDY;
            end
            T_RDY: if (s_ack) begin
               rdy_o <= 1'b0;
               oe_o  <= 1'b0;
               state <= T_END;
            end
            T_END: if (!s_ack) state <= T_IDLE;
            default: state <= T_IDLE;
         endcase
      end
   end

   // checker: target cycles since the address was captured
   int unsigned since_cap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        since_cap <= '0;
      else if (start)                    since_cap <= '0;
      else if (since_cap != 32'hFFFF_FFFF) since_cap <= since_cap + 1;
   end

   // R11
   latency_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_o) |-> (since_cap >= LATENCY));
   // R8
   rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_o) |-> (!req_i && !ack_i));
endmodule

// File: rtl/hsk_read_bus.sv
module hsk_read_bus #(
   parameter int AW          = 4,
   parameter int DW          = 16,
   parameter int LATENCY     = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk_ini,
   input  logic          rst_ini_n,
   input  logic          clk_tgt,
   input  logic          rst_tgt_n,
   input  logic          cmd_valid,
   input  logic [AW-1:0] cmd_addr,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] done_data,
   output logic          bus_req,
   output logic          bus_rdy,
   output logic          bus_ack,
   output logic [DW-1:0] bus_data,
   output logic          ini_drv_en,
   output logic          tgt_drv_en
);
   if (AW < 1 || AW > DW) begin : g_bad_aw
      $error("hsk_read_bus: AW must be between 1 and DW");
   end
   if (AW > 10) begin : g_big_mem
      $error("hsk_read_bus: AW too large for the internal array");
   end
   if (LATENCY < 0) begin : g_bad_lat
      $error("hsk_read_bus: LATENCY must not be negative");
   end

   logic          ini_ack, tgt_ack;
   logic [DW-1:0] ini_drv, tgt_drv;

   hsk_initiator #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_ini (
      .clk       (clk_ini),
      .rst_n     (rst_ini_n),
      .cmd_valid (cmd_valid),
      .cmd_addr  (cmd_addr),
      .busy      (busy),
      .done      (done),
      .done_data (done_data),
      .bus_i     (bus_data),
      .rdy_i     (bus_rdy),
      .ack_i     (bus_ack),
      .req_o     (bus_req),
      .ack_o     (ini_ack),
      .oe_o      (ini_drv_en),
      .drv_o     (ini_drv)
   );

   hsk_target #(.AW(AW), .DW(DW), .LATENCY(LATENCY), .SYNC_STAGES(SYNC_STAGES)) u_tgt (
      .clk   (clk_tgt),
      .rst_n (rst_tgt_n),
      .bus_i (bus_data),
      .req_i (bus_req),
      .ack_i (bus_ack),
      .rdy_o (bus_rdy),
      .ack_o (tgt_ack),
      .oe_o  (tgt_drv_en),
      .drv_o (tgt_drv)
   );

   // shared lines: drive enables select the owner, idle lines read as zero
   assign bus_ack  = ini_ack | tgt_ack;
   assign bus_data = ini_drv_en ? ini_drv : (tgt_drv_en ? tgt_drv : '0);

   // R6
   drive_excl_ini_chk: assert property (@(posedge clk_ini) disable iff (!rst_ini_n)
      !(ini_drv_en && tgt_drv_en));
   // R6
   drive_excl_tgt_chk: assert property (@(posedge clk_tgt) disable iff (!rst_tgt_n)
      !(ini_drv_en && tgt_drv_en));
endmodule

// File: tb/hsk_read_bus_tb.sv
module hsk_read_bus_tb;
   localparam int AW = 4;
   localparam int DW = 16;
   localparam int LAT_L = 12;
   localparam int LAT_S = 1;

   logic clk_ini = 1'b0, clk_tgt = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk_ini = ~clk_ini;
   initial begin #3; forever #7 clk_tgt = ~clk_tgt; end

   logic          cv_l = 1'b0, cv_s = 1'b0;
   logic [AW-1:0] ca_l = '0, ca_s = '0;
   logic          busy_l, done_l, req_l, rdy_l, ack_l, ie_l, te_l;
   logic          busy_s, done_s, req_s, rdy_s, ack_s, ie_s, te_s;
   logic [DW-1:0] dd_l, bd_l, dd_s, bd_s;

   hsk_read_bus #(.AW(AW), .DW(DW), .LATENCY(LAT_L)) u_dut (
      .clk_ini(clk_ini), .rst_ini_n(rst_n), .clk_tgt(clk_tgt), .rst_tgt_n(rst_n),
      .cmd_valid(cv_l), .cmd_addr(ca_l), .busy(busy_l), .done(done_l), .done_data(dd_l),
      .bus_req(req_l), .bus_rdy(rdy_l), .bus_ack(ack_l), .bus_data(bd_l),
      .ini_drv_en(ie_l), .tgt_drv_en(te_l));

   hsk_read_bus #(.AW(AW), .DW(DW), .LATENCY(LAT_S)) u_dut_short (
      .clk_ini(clk_ini), .rst_ini_n(rst_n), .clk_tgt(clk_tgt), .rst_tgt_n(rst_n),
      .cmd_valid(cv_s), .cmd_addr(ca_s), .busy(busy_s), .done(done_s), .done_data(dd_s),
      .bus_req(req_s), .bus_rdy(rdy_s), .bus_ack(ack_s), .bus_data(bd_s),
      .ini_drv_en(ie_s), .tgt_drv_en(te_s));

   int errors = 0, checks = 0;
   logic [DW-1:0] q_l[$], q_s[$];
   logic [AW-1:0] cur_l = '0, cur_s = '0;
   int accepted_l = 0, accepted_s = 0, dones_l = 0, dones_s = 0;
   bit overlap_l = 0, overlap_s = 0;
   bit prev_done_l = 0, prev_done_s = 0;

   function automatic logic [DW-1:0] expect_word(input int unsigned a);
      return DW'(a * 3869 + 11079);
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver: presents a command for one cycle; queues the expected word if accepted
   task automatic issue(input bit short_dut, input logic [AW-1:0] a);
      bit acc;
      @(negedge clk_ini);
      if (short_dut) begin
         ca_s = a; cv_s = 1'b1; acc = !busy_s;
         if (acc) begin q_s.push_back(expect_word(a)); cur_s = a; accepted_s++; end
      end else begin
         ca_l = a; cv_l = 1'b1; acc = !busy_l;
         if (acc) begin q_l.push_back(expect_word(a)); cur_l = a; accepted_l++; end
      end
      @(negedge clk_ini);
      cv_s = 1'b0; cv_l = 1'b0;
      if (acc) check(short_dut ? busy_s : busy_l, "R5 busy after accept", 0, 1);
   endtask

   task automatic wait_idle(input bit short_dut);
      do @(negedge clk_ini);
      while (short_dut ? (busy_s || q_s.size() != 0) : (busy_l || q_l.size() != 0));
   endtask

   // monitor / scoreboard
   always @(negedge clk_ini) if (rst_n) begin
      if (done_l) begin
         dones_l++;
         check(!prev_done_l, "R3 done width (long)", 1, 0);
         if (q_l.size() == 0) check(0, "R3 unexpected done (long)", dd_l, 0);
         else begin
            logic [DW-1:0] e;
            e = q_l.pop_front();
            check(dd_l == e, "R2 read word (long)", dd_l, e);
         end
      end
      if (done_s) begin
         dones_s++;
         check(!prev_done_s, "R3 done width (short)", 1, 0);
         if (q_s.size() == 0) check(0, "R3 unexpected done (short)", dd_s, 0);
         else begin
            logic [DW-1:0] e;
            e = q_s.pop_front();
            check(dd_s == e, "R2 read word (short)", dd_s, e);
         end
      end
      prev_done_l = done_l;
      prev_done_s = done_s;
   end

   always @(negedge clk_ini or negedge clk_tgt) begin
      if (ie_l && te_l) overlap_l = 1;
      if (ie_s && te_s) overlap_s = 1;
   end

   // control-wire ordering and bus contents (long-latency instance)
   initial forever begin
      @(posedge req_l); #1;
      check(bd_l == DW'(cur_l), "R7 address on bus (long)", bd_l, DW'(cur_l));
   end
   initial forever begin
      @(posedge rdy_l); #1;
      check(!req_l && !ack_l, "R8 rdy rise with req/ack low (long)", {req_l, ack_l}, 0);
      check(bd_l == expect_word(cur_l), "R7 word on bus (long)", bd_l, expect_word(cur_l));
   end
   initial forever begin
      @(negedge req_l); #1;
      check(ack_l, "R9 req drop under ack (long)", ack_l, 1);
   end
   initial forever begin
      @(negedge ack_l); #1;
      check(!rdy_l, "R10 ack drop with rdy low (long)", rdy_l, 0);
   end
   initial forever begin
      int n;
      @(posedge req_l);
      @(posedge ack_l);
      n = 0;
      while (!rdy_l) begin @(posedge clk_tgt); n++; #1; end
      check(n >= LAT_L && n <= LAT_L + 2, "R11 latency window", n, LAT_L + 1);
   end

   // same for the short-latency instance
   initial forever begin
      @(posedge req_s); #1;
      check(bd_s == DW'(cur_s), "R7 address on bus (short)", bd_s, DW'(cur_s));
   end
   initial forever begin
      @(posedge rdy_s); #1;
      check(!req_s && !ack_s, "R8 rdy rise with req/ack low (short)", {req_s, ack_s}, 0);
      check(bd_s == expect_word(cur_s), "R7 word on bus (short)", bd_s, expect_word(cur_s));
   end
   initial forever begin
      @(negedge req_s); #1;
      check(ack_s, "R9 req drop under ack (short)", ack_s, 1);
   end
   initial forever begin
      @(negedge ack_s); #1;
      check(!rdy_s, "R10 ack drop with rdy low (short)", rdy_s, 0);
   end
   initial forever begin
      int n;
      @(posedge req_s);
      @(posedge ack_s);
      n = 0;
      while (!rdy_s) begin @(posedge clk_tgt); n++; #1; end
      check(n > LAT_S + 2, "R12 rdy waits for return-to-zero", n, LAT_S + 3);
   end

   bit finished = 0;
   initial begin
      #2_000_000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk_ini);
      check({busy_l, done_l, req_l, rdy_l, ack_l, ie_l, te_l} == 0, "R1 reset state (long, in reset)",
            {busy_l, done_l, req_l, rdy_l, ack_l, ie_l, te_l}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk_ini);
      check({busy_l, done_l, req_l, rdy_l, ack_l, ie_l, te_l} == 0, "R1 idle after reset (long)",
            {busy_l, done_l, req_l, rdy_l, ack_l, ie_l, te_l}, 0);
      check({busy_s, done_s, req_s, rdy_s, ack_s, ie_s, te_s} == 0, "R1 idle after reset (short)",
            {busy_s, done_s, req_s, rdy_s, ack_s, ie_s, te_s}, 0);

      foreach (q_l[i]) ; // no-op keeps queue usage uniform
      for (int k = 0; k < 5; k++) begin
         logic [AW-1:0] a;
         a = AW'((k * 11 + 5) % 16);
         issue(0, a); wait_idle(0);
         issue(1, a); wait_idle(1);
      end
      issue(0, '1); wait_idle(0);
      issue(1, '0); wait_idle(1);

      // R4: command during a transaction is ignored
      issue(0, 4'd7);
      repeat (3) @(negedge clk_ini);
      check(busy_l, "R4 busy before second command", busy_l, 1);
      issue(0, 4'd9);
      wait_idle(0);
      check(cur_l == 4'd7, "R4 second command not taken", cur_l, 7);
      issue(1, 4'd3);
      issue(1, 4'd12);
      wait_idle(1);
      check(cur_s == 4'd3, "R4 second command not taken (short)", cur_s, 3);

      // back-to-back with the command held at each idle moment
      for (int k = 0; k < 4; k++) begin
         issue(0, AW'(k + 2));
         wait_idle(0);
      end
      repeat (20) @(negedge clk_ini);

      check(dones_l == accepted_l, "R3 one done per command (long)", dones_l, accepted_l);
      check(dones_s == accepted_s, "R3 one done per command (short)", dones_s, accepted_s);
      check(q_l.size() == 0 && q_s.size() == 0, "R3 no missing done", q_l.size() + q_s.size(), 0);
      check(!overlap_l, "R6 drive enables exclusive (long)", overlap_l, 0);
      check(!overlap_s, "R6 drive enables exclusive (short)", overlap_s, 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule